// File: doc/BRIEF.md
# Peripheral Bus Transfer Sequencer

This block turns commands from a valid/ready command port into accesses on a simple low-bandwidth peripheral bus. Each command carries an address, a write flag and write data. The block runs every access through three phases: idle, setup and enable. In setup it drives the address, the write flag, the write data and a one-hot peripheral select. In enable it raises the enable strobe for one cycle. It samples the returned read data at the edge that closes the enable phase, then acknowledges the command.

No access has wait states, so every transfer takes exactly two bus cycles. The command port also takes a request during the enable cycle. That request goes straight into the next setup phase without an idle cycle between them, which lets a master stream accesses at one transfer every two cycles. The select is chosen by a field of upper address bits. An address whose field names no existing peripheral is rejected with a decode error and drives nothing on the bus.

Top module: `pbus_seq`

## Requirements
- R1: After reset, `pb_sel_o` is all zero, `pb_en_o`, `cmd_ack_o` and `cmd_err_o` are low, and `cmd_ready_o` is high.
- R2: When a request with address field `addr[15:12]` below 4 is accepted (`cmd_valid_i` and `cmd_ready_o` both high at a clock edge), the next cycle is a setup cycle. In that cycle `pb_sel_o` has only bit `addr[15:12]` set, `pb_en_o` is low, and `pb_addr_o`, `pb_write_o` and `pb_wdata_o` equal the command's values.
- R3: A setup cycle always lasts one cycle and is followed by an enable cycle. In the enable cycle `pb_en_o` is high, and address, write flag, write data and select are unchanged from setup.
- R4: An enable cycle lasts one cycle. At the edge that ends it, `pb_rdata_i` is captured. In the following cycle `cmd_ack_o` is high for one cycle and `cmd_rdata_o` holds the captured value.
- R5: `cmd_ready_o` is high only in idle and enable cycles. A request presented only during a setup cycle is ignored: no access follows once the current one ends.
- R6: A valid request accepted in the enable cycle starts its setup cycle directly in the next cycle, with the new select, address and write values and no idle cycle in between.
- R7: A request accepted with `addr[15:12]` of 4 or more raises `cmd_err_o` for exactly the next cycle. It drives no select and no enable, never raises `cmd_ack_o`, and leaves the machine idle.
- R8: `pb_en_o` is never high while `pb_sel_o` is zero, and `pb_sel_o` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Command can be accepted this cycle |
| cmd_addr_i | input | 16 | Command address |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_wdata_i | input | 32 | Write data |
| cmd_ack_o | output | 1 | One-cycle completion pulse |
| cmd_rdata_o | output | 32 | Read data captured at end of enable |
| cmd_err_o | output | 1 | One-cycle decode error pulse |
| pb_addr_o | output | 16 | Peripheral bus address |
| pb_write_o | output | 1 | Peripheral bus write flag |
| pb_wdata_o | output | 32 | Peripheral bus write data |
| pb_sel_o | output | 4 | One-hot peripheral select |
| pb_en_o | output | 1 | Enable strobe |
| pb_rdata_i | input | 32 | Read data from the selected peripheral |

## Verification
Isolated single accesses sweep all sixteen values of the select field for both reads and writes. This covers every one-hot select, separates valid fields from rejected ones, and checks the exact cycle of ack and error. Back-to-back pairs over every combination of peripherals, plus pairs whose second command is out of range, show that the follow-on setup comes straight after enable with the new select and that the error path leaves the machine idle. A request offered only during setup shows that it is dropped rather than queued. Read data comes from an address-dependent model, which shows that the data is captured from the access that just ended.

// File: rtl/pbus_seq_pkg.sv
package pbus_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ENABLE = 2'd2
  } pb_state_e;
endpackage

// File: rtl/pbus_seq_dec.sv
module pbus_seq_dec #(
  parameter int SEL_W    = 4,
  parameter int N_PERIPH = 4
) (
  input  logic [SEL_W-1:0]    field_i,
  output logic [N_PERIPH-1:0] sel_o,
  output logic                hit_o
);
  for (genvar i = 0; i < N_PERIPH; i++) begin : g_sel
    assign sel_o[i] = (field_i == SEL_W'(i));
  end
  assign hit_o = |sel_o;
endmodule

// File: rtl/pbus_seq_fsm.sv
module pbus_seq_fsm
  import pbus_seq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      take_i,
  output pb_state_e state_o,
  output logic      ready_o
);
  pb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   state_d = take_i ? ST_SETUP : ST_IDLE;
      ST_SETUP:  state_d = ST_ENABLE;
      ST_ENABLE: state_d = take_i ? ST_SETUP : ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  // Pipelined acceptance: one command may queue behind the enable phase
  assign ready_o = (state_q == ST_IDLE) || (state_q == ST_ENABLE);
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_seq_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int SEL_LSB  = 12,
  parameter int SEL_W    = 4,
  parameter int N_PERIPH = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  output logic                cmd_ready_o,
  input  logic [ADDR_W-1:0]   cmd_addr_i,
  input  logic                cmd_write_i,
  input  logic [DATA_W-1:0]   cmd_wdata_i,
  output logic                cmd_ack_o,
  output logic [DATA_W-1:0]   cmd_rdata_o,
  output logic                cmd_err_o,
  output logic [ADDR_W-1:0]   pb_addr_o,
  output logic                pb_write_o,
  output logic [DATA_W-1:0]   pb_wdata_o,
  output logic [N_PERIPH-1:0] pb_sel_o,
  output logic                pb_en_o,
  input  logic [DATA_W-1:0]   pb_rdata_i
);
  pb_state_e             state;
  logic                  ready, accept, take, bad, hit;
  logic [N_PERIPH-1:0]   sel_dec, sel_q;
  logic [ADDR_W-1:0]     addr_q;
  logic                  write_q;
  logic [DATA_W-1:0]     wdata_q, rdata_q;
  logic                  ack_q, err_q;

  pbus_seq_dec #(.SEL_W(SEL_W), .N_PERIPH(N_PERIPH)) u_dec (
    .field_i (cmd_addr_i[SEL_LSB +: SEL_W]),
    .sel_o   (sel_dec),
    .hit_o   (hit)
  );

  assign accept = cmd_valid_i && ready;
  assign take   = accept && hit;
  assign bad    = accept && !hit;

  pbus_seq_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (take),
    .state_o (state),
    .ready_o (ready)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
      sel_q   <= '0;
    end else if (take) begin
      addr_q  <= cmd_addr_i;
      write_q <= cmd_write_i;
      wdata_q <= cmd_wdata_i;
      sel_q   <= sel_dec;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      ack_q <= (state == ST_ENABLE);
      err_q <= bad;
      if (state == ST_ENABLE) rdata_q <= pb_rdata_i;
    end
  end

  assign cmd_ready_o = ready;
  assign cmd_ack_o   = ack_q;
  assign cmd_err_o   = err_q;
  assign cmd_rdata_o = rdata_q;
  assign pb_addr_o   = addr_q;
  assign pb_write_o  = write_q;
  assign pb_wdata_o  = wdata_q;
  assign pb_sel_o    = (state == ST_IDLE) ? '0 : sel_q;
  assign pb_en_o     = (state == ST_ENABLE);
endmodule

// File: rtl/pbus_seq_chk.sv
module pbus_seq_chk #(
  parameter int ADDR_W   = 16,
  parameter int SEL_LSB  = 12,
  parameter int SEL_W    = 4,
  parameter int N_PERIPH = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cmd_valid_i,
  input logic                cmd_ready_o,
  input logic [ADDR_W-1:0]   cmd_addr_i,
  input logic                cmd_ack_o,
  input logic                cmd_err_o,
  input logic [ADDR_W-1:0]   pb_addr_o,
  input logic                pb_write_o,
  input logic [N_PERIPH-1:0] pb_sel_o,
  input logic                pb_en_o
);
  logic setup_c, good_acc;
  assign setup_c  = (|pb_sel_o) && !pb_en_o;
  assign good_acc = cmd_valid_i && cmd_ready_o &&
                    (32'(cmd_addr_i[SEL_LSB +: SEL_W]) < N_PERIPH);

  a_r2_accept_to_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good_acc |=> setup_c);
  a_r3_setup_to_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_c |=> pb_en_o);
  a_r3_hold_in_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_c |=> ($stable(pb_addr_o) && $stable(pb_write_o) && $stable(pb_sel_o)));
  a_r4_enable_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pb_en_o |=> !pb_en_o);
  a_r4_ack_after_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pb_en_o |=> cmd_ack_o);
  a_r4_ack_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ack_o |-> $past(pb_en_o));
  a_r5_busy_in_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_c |-> !cmd_ready_o);
  a_r7_err_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o |-> (pb_sel_o == '0));
  a_r8_en_needs_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pb_en_o |-> (|pb_sel_o));
  a_r8_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pb_sel_o));
endmodule

bind pbus_seq pbus_seq_chk #(
  .ADDR_W(ADDR_W), .SEL_LSB(SEL_LSB), .SEL_W(SEL_W), .N_PERIPH(N_PERIPH)
) u_chk (.*);

// File: tb/pbus_seq_bench.sv
module pbus_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        ready;
  logic [15:0] addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic        ack, err;
  logic [31:0] rdata;
  logic [15:0] pb_addr;
  logic        pb_write;
  logic [31:0] pb_wdata;
  logic [3:0]  pb_sel;
  logic        pb_en;
  logic [31:0] pb_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // peripheral model: read data depends on presented address
  assign pb_rdata = {~pb_addr, pb_addr};

  pbus_seq u_pbus_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(valid), .cmd_ready_o(ready), .cmd_addr_i(addr),
    .cmd_write_i(wr), .cmd_wdata_i(wdata),
    .cmd_ack_o(ack), .cmd_rdata_o(rdata), .cmd_err_o(err),
    .pb_addr_o(pb_addr), .pb_write_o(pb_write), .pb_wdata_o(pb_wdata),
    .pb_sel_o(pb_sel), .pb_en_o(pb_en), .pb_rdata_i(pb_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_sel(input logic [15:0] a);
    return (a[15:12] < 4) ? (4'b1 << a[15:12]) : 4'b0;
  endfunction

  function automatic logic [15:0] mk_addr(input int f, input int k);
    return {4'(f), 12'(k * 52 + 4)};
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic drive(input logic [15:0] a, input logic w, input logic [31:0] d);
    valid = 1'b1; addr = a; wr = w; wdata = d;
  endtask

  task automatic chk_setup(input logic [15:0] a, input logic w, input logic [31:0] d);
    chk(pb_sel == exp_sel(a), "R2 sel", 64'(pb_sel), 64'(exp_sel(a)));
    chk(!pb_en, "R2 en low", 64'(pb_en), 0);
    chk(pb_addr == a && pb_write == w && pb_wdata == d, "R2 addr/write/data",
        {15'd0, pb_write, pb_addr, pb_wdata}, {15'd0, w, a, d});
    chk(!ready, "R5 not ready in setup", 64'(ready), 0);
  endtask

  task automatic chk_enable(input logic [15:0] a, input logic w, input logic [31:0] d);
    chk(pb_en, "R3 en high", 64'(pb_en), 1);
    chk(pb_sel == exp_sel(a) && pb_addr == a && pb_write == w && pb_wdata == d,
        "R3 hold", {11'd0, pb_sel, pb_write, pb_addr, pb_wdata},
        {11'd0, exp_sel(a), w, a, d});
    chk(ready, "R5 ready in enable", 64'(ready), 1);
  endtask

  task automatic chk_ack(input logic [15:0] a);
    chk(ack, "R4 ack", 64'(ack), 1);
    chk(rdata == {~a, a}, "R4 rdata", 64'(rdata), 64'({~a, a}));
  endtask

  task automatic single(input logic [15:0] a, input logic w, input logic [31:0] d);
    drive(a, w, d);
    chk(ready, "R1 ready idle", 64'(ready), 1);
    step(); valid = 1'b0;
    if (a[15:12] < 4) begin
      chk_setup(a, w, d);
      step(); chk_enable(a, w, d);
      step(); chk_ack(a);
      chk(pb_sel == 0 && !pb_en, "R4 back to idle", 64'(pb_sel), 0);
      step(); chk(!ack, "R4 ack one cycle", 64'(ack), 0);
    end else begin
      chk(err && pb_sel == 0 && !pb_en, "R7 err, no select", {pb_sel, err}, 1);
      step();
      chk(!err && !ack && pb_sel == 0, "R7 err one cycle, no ack",
          {pb_sel, ack, err}, 0);
    end
  endtask

  task automatic pair(input logic [15:0] a1, input logic [15:0] a2);
    drive(a1, 1'b1, {16'h1111, a1});
    step(); valid = 1'b0;
    chk_setup(a1, 1'b1, {16'h1111, a1});
    step(); chk_enable(a1, 1'b1, {16'h1111, a1});
    drive(a2, 1'b0, {16'h2222, a2});
    step(); valid = 1'b0;
    chk_ack(a1);
    if (a2[15:12] < 4) begin
      chk_setup(a2, 1'b0, {16'h2222, a2}); // R6 no idle gap
      chk(pb_sel == exp_sel(a2), "R6 direct setup", 64'(pb_sel), 64'(exp_sel(a2)));
      step(); chk_enable(a2, 1'b0, {16'h2222, a2});
      step(); chk_ack(a2);
    end else begin
      chk(err && pb_sel == 0, "R7 err after enable", {pb_sel, err}, 1);
    end
    step();
    chk(pb_sel == 0 && !pb_en, "R6 idle after pair", {pb_sel, pb_en}, 0);
  endtask

  initial begin
    step();
    chk(pb_sel == 0 && !pb_en && !ack && !err && ready, "R1 reset",
        {pb_sel, pb_en, ack, err, ready}, 1);
    rst_n = 1'b1;
    step();
    for (int f = 0; f < 16; f++)
      for (int w = 0; w < 2; w++)
        single(mk_addr(f, f + w), 1'(w), 32'(f * 4099 + w));
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 5; j++)
        pair(mk_addr(i, j), mk_addr((j == 4) ? 9 : j, i + 1));
    // R5: request offered only in setup is dropped
    drive(mk_addr(2, 7), 1'b0, 32'h0);
    step(); drive(mk_addr(1, 3), 1'b1, 32'hdead);
    step(); valid = 1'b0;
    chk_enable(mk_addr(2, 7), 1'b0, 32'h0);
    step(); chk_ack(mk_addr(2, 7));
    chk(pb_sel == 0, "R5 setup request ignored", 64'(pb_sel), 0);
    step();
    chk(pb_sel == 0 && !pb_en && !ack, "R5 still idle", {pb_sel, pb_en, ack}, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule